// File: doc/BRIEF.md
# Character frame buffer controller

This block holds one full text screen in a single-ported character store of 2480 sixteen-bit words, arranged as 31 rows of 80 columns. Two clients share the store. The host side, normally the I/O processor, writes character words and can read them back for diagnostics. The refresh side streams the frame out one word per load strobe, toward a line buffer that feeds the display.

Each cycle the block chooses one owner for the memory. A refresh load always wins. A host request that arrives in the same cycle is held off by deasserting `host_ready` until a cycle with no load. The refresh address counter steps once per load and wraps after the last location. A page-start pulse brings it back to location 0, so each frame is read from its first word. The block drives the write-enable and output-enable strobes and the gate that cuts the host data path off from the memory bus while refresh owns it.

Top module: `char_frame_ctrl`

## Requirements
- R1: After synchronous reset, `ref_addr` is 0 and both `host_rvalid` and `ref_valid` are low.
- R2: A host request is accepted in a cycle where `host_valid` and `host_ready` are both high. `host_write` = 1 selects a write and 0 selects a read. An accepted read produces `host_rvalid` high in the next cycle, with `host_rdata` equal to the word last written to that address.
- R3: When `ref_load` is high, the word at the current refresh address is read. In the next cycle `ref_valid` is high and `ref_data` carries that word. `ref_addr` then advances by one.
- R4: A load taken at refresh address 2479 returns that word and sets `ref_addr` to 0.
- R5: `page_start` high sets `ref_addr` to 0. If `ref_load` is high in the same cycle, the load reads location 0 and `ref_addr` becomes 1.
- R6: Refresh has priority. `host_ready` is low in every cycle where `ref_load` is high, and a host request held in such a cycle leaves the store unchanged.
- R7: A host write to an address of 2480 or above changes no location and does not raise `mem_we`. A host read of such an address returns 0.
- R8: `mem_we` is high only in a cycle that accepts a host write to an in-range address.
- R9: `mem_oe` is high in every refresh load cycle and every accepted host write cycle. It is low in idle cycles and in host read cycles.
- R10: `host_gate` is high exactly in cycles where `ref_load` is high, and is never high together with `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host request can be accepted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 16 | Host read data |
| ref_load | input | 1 | Refresh load strobe, one word per cycle |
| page_start | input | 1 | New-frame pulse, resets the refresh address |
| ref_addr | output | 12 | Current refresh address |
| ref_valid | output | 1 | Refresh data valid |
| ref_data | output | 16 | Refresh word toward the line buffer |
| mem_we | output | 1 | Memory write-enable strobe |
| mem_oe | output | 1 | Memory output-enable strobe |
| host_gate | output | 1 | High while the host data path is isolated |

## Verification
Every location is written with an address-derived pattern and read back through the host port, which exposes stuck or aliased address bits. A full frame plus extra loads is then streamed through the refresh port, which checks sequential stepping and the wrap from 2479 to 0. Page-start pulses are applied alone, with a load, and mid-frame, which tells a counter reset apart from a realigned load. Collision cycles and out-of-range addresses (2480 and 4095) separate a host access that is correctly stalled or dropped from one that corrupts the store or aliases onto a valid word.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int ROWS   = 31;
    localparam int COLS   = 80;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = ROWS * COLS;

    typedef enum logic [1:0] {
        OWN_IDLE    = 2'd0,
        OWN_REFRESH = 2'd1,
        OWN_HOST_WR = 2'd2,
        OWN_HOST_RD = 2'd3
    } owner_e;

    typedef struct packed {
        owner_e             owner;
        logic               in_range;
        logic [ADDR_W-1:0]  addr;
    } access_t;

    function automatic logic addr_in_range(input logic [ADDR_W-1:0] a, input int depth);
        return int'(a) < depth;
    endfunction
endpackage

// File: rtl/cfb_refresh_ctr.sv
module cfb_refresh_ctr #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              page_start,
    output logic [ADDR_W-1:0] cnt,
    output logic [ADDR_W-1:0] addr_eff
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // A page pulse realigns the address used in the same cycle.
    assign addr_eff = page_start ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (addr_eff == LAST) ? '0 : addr_eff + 1'b1;
        end else if (page_start) begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/cfb_arbiter.sv
module cfb_arbiter
    import cfb_pkg::*;
#(
    parameter int DEPTH = 2480
) (
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ref_load,
    input  logic [ADDR_W-1:0] ref_addr_eff,
    output access_t           acc,
    output logic              host_ready,
    output logic              mem_we,
    output logic              mem_oe,
    output logic              host_gate
);
    logic host_ok;

    assign host_ready = !ref_load;
    assign host_ok    = addr_in_range(host_addr, DEPTH);

    always_comb begin
        acc = '{owner: OWN_IDLE, in_range: 1'b0, addr: '0};
        if (ref_load) begin
            acc = '{owner: OWN_REFRESH, in_range: 1'b1, addr: ref_addr_eff};
        end else if (host_valid) begin
            acc.owner    = host_write ? OWN_HOST_WR : OWN_HOST_RD;
            acc.in_range = host_ok;
            acc.addr     = host_ok ? host_addr : '0;
        end
    end

    assign mem_we    = (acc.owner == OWN_HOST_WR) && acc.in_range;
    assign mem_oe    = (acc.owner == OWN_HOST_WR) || (acc.owner == OWN_REFRESH);
    assign host_gate = (acc.owner == OWN_REFRESH);
endmodule

// File: rtl/cfb_store.sv
module cfb_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2480
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rd_q <= mem[addr];
    end
endmodule

// File: rtl/char_frame_ctrl.sv
module char_frame_ctrl
    import cfb_pkg::*;
#(
    parameter int N_ROWS = cfb_pkg::ROWS,
    parameter int N_COLS = cfb_pkg::COLS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ref_load,
    input  logic              page_start,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              ref_valid,
    output logic [DATA_W-1:0] ref_data,
    output logic              mem_we,
    output logic              mem_oe,
    output logic              host_gate
);
    localparam int N_WORDS = N_ROWS * N_COLS;

    access_t           acc;
    logic [ADDR_W-1:0] ref_addr_eff;
    logic [DATA_W-1:0] rd_q;
    owner_e            owner_q;
    logic              in_range_q;

    cfb_refresh_ctr #(.ADDR_W(ADDR_W), .DEPTH(N_WORDS)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .load       (ref_load),
        .page_start (page_start),
        .cnt        (ref_addr),
        .addr_eff   (ref_addr_eff)
    );

    cfb_arbiter #(.DEPTH(N_WORDS)) u_arb (
        .host_valid   (host_valid),
        .host_write   (host_write),
        .host_addr    (host_addr),
        .ref_load     (ref_load),
        .ref_addr_eff (ref_addr_eff),
        .acc          (acc),
        .host_ready   (host_ready),
        .mem_we       (mem_we),
        .mem_oe       (mem_oe),
        .host_gate    (host_gate)
    );

    cfb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(N_WORDS)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (acc.addr),
        .wdata (host_wdata),
        .rd_q  (rd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q    <= OWN_IDLE;
            in_range_q <= 1'b0;
        end else begin
            owner_q    <= acc.owner;
            in_range_q <= acc.in_range;
        end
    end

    assign ref_valid   = (owner_q == OWN_REFRESH);
    assign ref_data    = ref_valid ? rd_q : '0;
    assign host_rvalid = (owner_q == OWN_HOST_RD);
    assign host_rdata  = (host_rvalid && in_range_q) ? rd_q : '0;
endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2480
) (
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_write,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              ref_load,
    input logic              page_start,
    input logic [ADDR_W-1:0] ref_addr,
    input logic              ref_valid,
    input logic              mem_we,
    input logic              mem_oe,
    input logic              host_gate
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    p_stall_r6: assert property (@(posedge clk) disable iff (rst)
        ref_load |-> !host_ready);

    p_we_accept_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (host_valid && host_write && host_ready));

    p_oe_cover_r9: assert property (@(posedge clk) disable iff (rst)
        (ref_load || mem_we) |-> mem_oe);

    p_gate_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({host_gate, mem_we}));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_load && !page_start && ref_addr != LAST) |=>
            (ref_addr == ADDR_W'($past(ref_addr) + 1'b1)) && ref_valid);

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_load && !page_start && ref_addr == LAST) |=> (ref_addr == '0));

    p_page_r5: assert property (@(posedge clk) disable iff (rst)
        (page_start && !ref_load) |=> (ref_addr == '0));

    p_read_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (host_valid && !host_write && host_ready) |=> host_rvalid);
endmodule

bind char_frame_ctrl cfb_checker #(.ADDR_W(cfb_pkg::ADDR_W), .DEPTH(N_WORDS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .ref_load    (ref_load),
    .page_start  (page_start),
    .ref_addr    (ref_addr),
    .ref_valid   (ref_valid),
    .mem_we      (mem_we),
    .mem_oe      (mem_oe),
    .host_gate   (host_gate)
);

// File: tb/tb_char_frame_ctrl.sv
module tb_char_frame_ctrl;
    localparam int DEPTH = 2480;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_valid, host_write;
    logic [11:0] host_addr;
    logic [15:0] host_wdata;
    logic        host_ready, host_rvalid;
    logic [15:0] host_rdata;
    logic        ref_load, page_start;
    logic [11:0] ref_addr;
    logic        ref_valid;
    logic [15:0] ref_data;
    logic        mem_we, mem_oe, host_gate;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    char_frame_ctrl dut (.*);

    always #2 clk = ~clk;

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 37 + 16'h1234) ^ (a << 9));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_valid = 0; host_write = 0; host_addr = '0; host_wdata = '0;
        ref_load = 0; page_start = 0;
    endtask

    // Drive a write at a negedge, observe strobes, then leave one cycle.
    task automatic host_wr(input int a, input logic [15:0] d, input bit in_range);
        @(negedge clk);
        host_valid = 1; host_write = 1; host_addr = 12'(a); host_wdata = d;
        #0.5;
        check("R8 we on write", {31'd0, mem_we}, {31'd0, in_range});
        check("R9 oe on write", {31'd0, mem_oe}, 32'd1);
        @(negedge clk);
        idle();
    endtask

    task automatic host_rd(input int a, input logic [15:0] exp, input string req);
        @(negedge clk);
        host_valid = 1; host_write = 0; host_addr = 12'(a);
        #0.5;
        check("R9 oe low on read", {31'd0, mem_oe}, 32'd0);
        @(negedge clk);
        idle();
        check("R2 rvalid", {31'd0, host_rvalid}, 32'd1);
        check(req, {16'd0, host_rdata}, {16'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_a;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 ref_addr", {20'd0, ref_addr}, 32'd0);
        check("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
        check("R1 ref_valid", {31'd0, ref_valid}, 32'd0);
        check("R9 oe idle", {31'd0, mem_oe}, 32'd0);

        // R2 sweep: fill the whole store, read it all back
        for (int a = 0; a < DEPTH; a++) host_wr(a, pat(a), 1'b1);
        for (int a = 0; a < DEPTH; a++) host_rd(a, pat(a), "R2 readback");

        // R7 out-of-range writes ignored, reads zero, no aliasing
        host_wr(2480, 16'hDEAD, 1'b0);
        host_wr(4095, 16'hBEEF, 1'b0);
        host_wr(2480 + 432, 16'hCAFE, 1'b0);
        host_rd(2480, 16'h0000, "R7 oor read zero");
        host_rd(4095, 16'h0000, "R7 oor read zero");
        host_rd(432, pat(432), "R7 no alias");
        host_rd(0, pat(0), "R7 no alias");
        host_rd(2479 - 2048, pat(2479 - 2048), "R7 no alias");

        // R3/R4: stream a full frame plus five extra loads back to back
        exp_a = 0;
        @(negedge clk);
        for (int k = 0; k < DEPTH + 5; k++) begin
            check("R3 ref_addr", {20'd0, ref_addr}, 32'(exp_a));
            ref_load = 1;
            #0.5;
            check("R10 gate", {31'd0, host_gate}, 32'd1);
            check("R9 oe refresh", {31'd0, mem_oe}, 32'd1);
            @(negedge clk);
            check("R3 ref_valid", {31'd0, ref_valid}, 32'd1);
            check((exp_a == DEPTH - 1) ? "R4 wrap data" : "R3 data",
                  {16'd0, ref_data}, {16'd0, pat(exp_a)});
            exp_a = (exp_a == DEPTH - 1) ? 0 : exp_a + 1;
        end
        ref_load = 0;
        check("R4 addr after wrap", {20'd0, ref_addr}, 32'd5);
        @(negedge clk);
        check("R3 valid drops", {31'd0, ref_valid}, 32'd0);
        check("R10 gate idle", {31'd0, host_gate}, 32'd0);

        // R5 page pulse alone mid-frame
        page_start = 1;
        @(negedge clk);
        page_start = 0;
        check("R5 page alone", {20'd0, ref_addr}, 32'd0);
        // step to 7, then page with load
        repeat (7) begin ref_load = 1; @(negedge clk); end
        ref_load = 0;
        check("R3 addr 7", {20'd0, ref_addr}, 32'd7);
        ref_load = 1; page_start = 1;
        @(negedge clk);
        ref_load = 0; page_start = 0;
        check("R5 page+load data", {16'd0, ref_data}, {16'd0, pat(0)});
        check("R5 page+load addr", {20'd0, ref_addr}, 32'd1);

        // R6 collision: host write stalled while refresh loads
        @(negedge clk);
        ref_load = 1;
        host_valid = 1; host_write = 1; host_addr = 12'd5; host_wdata = 16'h5A5A;
        #0.5;
        check("R6 ready low", {31'd0, host_ready}, 32'd0);
        check("R10 no we with gate", {31'd0, mem_we}, 32'd0);
        @(negedge clk);
        ref_load = 0;
        host_valid = 0;
        host_rd(5, pat(5), "R6 stalled write no effect");
        // stalled read: no rvalid in the collision cycle's follow-up
        @(negedge clk);
        ref_load = 1; host_valid = 1; host_write = 0; host_addr = 12'd9;
        @(negedge clk);
        check("R6 stalled read no rvalid", {31'd0, host_rvalid}, 32'd0);
        ref_load = 0;
        #0.5;
        check("R6 ready returns", {31'd0, host_ready}, 32'd1);
        @(negedge clk);
        idle();
        check("R6 read after stall", {16'd0, host_rdata}, {16'd0, pat(9)});
        host_wr(5, 16'h5A5A, 1'b1);
        host_rd(5, 16'h5A5A, "R2 write after stall");

        // R1 reset mid-run
        repeat (3) begin ref_load = 1; @(negedge clk); end
        ref_load = 0;
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset ref_addr", {20'd0, ref_addr}, 32'd0);
        check("R1 reset ref_valid", {31'd0, ref_valid}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule